// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarms

This block keeps wall-clock time as a binary seconds count plus a millisecond count, advanced by a slow tick strobe (nominally 32 kHz) that arrives as a one-cycle enable in the bus clock domain. A prescaler turns a set number of slow ticks into one millisecond. A set number of milliseconds makes one second. Software does not see the live counters. It sees a bus-side copy that is refreshed after every eighth slow tick. While that refresh is in progress a busy flag is raised, and any register write that arrives during that window is dropped.

Reading the millisecond view also captures the seconds view into a shadow register in the same access. A later read of the shadow therefore returns the seconds that belong to the millisecond value just read. Two seconds-match alarms, one millisecond-match alarm and two periodic sources (one per second, one per millisecond) feed an interrupt block. That block holds a sticky status register cleared by writing ones, plus a mask. A single active-high level interrupt output signals any pending event that is enabled by its mask bit.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the busy flag, the seconds and millisecond views, the shadow, all alarms, the mask, the status and `irq` are all 0.
- R2: After every eighth slow tick since reset, register 0x00 reads 1 in bit 0 (busy) for BUSY_LEN bus cycles, starting the cycle after that tick. At all other times it reads 0.
- R3: A bus write issued while busy is 1 changes no register.
- R4: The prescaler produces one millisecond step every TICKS_PER_MS ticks. The millisecond count wraps from MS_PER_SEC-1 to 0 and adds one to the seconds count. The seconds view (0x04) and millisecond view (0x0C) hold the counter values as they stand after the most recent eighth tick.
- R5: A read of the millisecond view (0x0C) loads the seconds view into the shadow register (0x08). No other event changes the shadow.
- R6: A write to the seconds register (0x04) loads the live seconds counter and clears the millisecond count and the prescaler. The seconds view shows the new value only after the next refresh.
- R7: Seconds alarm A (0x10) sets status bit 0 and seconds alarm B (0x14) sets status bit 1 when a seconds step makes the seconds count equal to the alarm value. An alarm value of 0 never sets its bit, even when the count wraps to 0.
- R8: The millisecond alarm (0x18, MS_W bits) sets status bit 2 when a millisecond step makes the count equal to it. Each seconds step sets bit 3, and each millisecond step sets bit 4.
- R9: Writing the status register (0x20) clears every status bit written as 1 and leaves the bits written as 0 unchanged.
- R10: Status bits are set whether masked or not. `irq` is 1 exactly while some status bit and the same bit of the mask (0x1C, five bits) are both 1.
- R11: When a status clear and a new event for the same bit fall in the same cycle, the bit ends up set.
- R12: The alarms and the mask read back what was written, truncated to their widths: 32 bits for the seconds alarms, MS_W bits for the millisecond alarm and 5 bits for the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word aligned, register index in bits [ADDR_W-1:2] |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read |
| irq | output | 1 | Level-high interrupt |

## Verification
The assertions assume that `slow_tick` is a clean one-cycle strobe in the bus clock domain and that software honours the busy flag. They do not, however, assume that writes never collide with busy, because the ignore rule is itself checked. They also assume that events and status clears may share a cycle. The stimulus spaces the ticks several bus cycles apart, so that every refresh window closes before the next access. It issues one write deliberately inside a busy window, and it lines up one tick with a status clear to force the collision case.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   // Interrupt source positions; software decodes these bit numbers.
   localparam int NUM_EV     = 5;
   localparam int NUM_SEC_AL = 2;
   localparam int EV_SAL_A   = 0;
   localparam int EV_SAL_B   = 1;
   localparam int EV_MSAL    = 2;
   localparam int EV_SEC     = 3;
   localparam int EV_MS      = 4;

   // Word index of each register (byte address = index * 4).
   typedef enum logic [3:0] {
      RG_BUSY   = 4'd0,
      RG_SEC    = 4'd1,
      RG_SHADOW = 4'd2,
      RG_MS     = 4'd3,
      RG_SAL_A  = 4'd4,
      RG_SAL_B  = 4'd5,
      RG_MSAL   = 4'd6,
      RG_MASK   = 4'd7,
      RG_STAT   = 4'd8
   } reg_idx_e;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase import rtc_pkg::*; #(
   parameter int SEC_W        = 32,
   parameter int MS_W         = 10,
   parameter int TICKS_PER_MS = 32,
   parameter int MS_PER_SEC   = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [SEC_W-1:0] load_val,
   input  logic [SEC_W-1:0] al_sec [NUM_SEC_AL],
   input  logic [MS_W-1:0]  al_ms,
   output logic [SEC_W-1:0] sec_nxt,
   output logic [MS_W-1:0]  ms_nxt,
   output logic [NUM_EV-1:0] ev
);
   localparam int PRE_W = $clog2(TICKS_PER_MS);

   logic [PRE_W-1:0] pre_q;
   logic [MS_W-1:0]  ms_q;
   logic [SEC_W-1:0] sec_q;
   logic             ms_step, sec_step;
   logic [NUM_SEC_AL-1:0] sal_hit;
   logic             msal_hit;

   always_comb begin
      ms_step  = tick && (pre_q == PRE_W'(TICKS_PER_MS - 1));
      sec_step = ms_step && (ms_q == MS_W'(MS_PER_SEC - 1));
      if (load) begin
         sec_nxt = load_val;
         ms_nxt  = '0;
      end else begin
         sec_nxt = sec_step ? sec_q + SEC_W'(1) : sec_q;
         ms_nxt  = sec_step ? '0 : (ms_step ? ms_q + MS_W'(1) : ms_q);
      end
   end

   // One comparator per seconds alarm; zero disables the alarm.
   for (genvar k = 0; k < NUM_SEC_AL; k++) begin : g_sal
      assign sal_hit[k] = sec_step && !load && (al_sec[k] != '0) && (sec_nxt == al_sec[k]);
   end
   assign msal_hit = ms_step && !load && (ms_nxt == al_ms);
   assign ev = {ms_step && !load, sec_step && !load, msal_hit, sal_hit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         ms_q  <= '0;
         sec_q <= '0;
      end else if (load) begin
         pre_q <= '0;
         ms_q  <= '0;
         sec_q <= load_val;
      end else if (tick) begin
         pre_q <= ms_step ? '0 : pre_q + PRE_W'(1);
         ms_q  <= ms_nxt;
         sec_q <= sec_nxt;
      end
   end
endmodule

// File: rtl/rtc_sync_view.sv
module rtc_sync_view #(
   parameter int SEC_W      = 32,
   parameter int MS_W       = 10,
   parameter int SYNC_TICKS = 8,
   parameter int BUSY_LEN   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [SEC_W-1:0] sec_nxt,
   input  logic [MS_W-1:0]  ms_nxt,
   input  logic             snap,
   output logic             busy,
   output logic [SEC_W-1:0] view_sec,
   output logic [MS_W-1:0]  view_ms,
   output logic [SEC_W-1:0] shadow
);
   localparam int PH_W = $clog2(SYNC_TICKS);
   localparam int BW   = $clog2(BUSY_LEN + 1);

   logic [PH_W-1:0] phase_q;
   logic [BW-1:0]   busy_q;
   logic            copy;

   assign copy = tick && (phase_q == PH_W'(SYNC_TICKS - 1));
   assign busy = (busy_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= '0;
         busy_q   <= '0;
         view_sec <= '0;
         view_ms  <= '0;
         shadow   <= '0;
      end else begin
         if (tick) phase_q <= phase_q + PH_W'(1);
         if (copy) begin
            busy_q   <= BW'(BUSY_LEN);
            view_sec <= sec_nxt;
            view_ms  <= ms_nxt;
         end else if (busy) begin
            busy_q <= busy_q - BW'(1);
         end
         // Captures the seconds that pair with the millisecond value read now.
         if (snap) shadow <= view_sec;
      end
   end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
   parameter int NB = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] ev,
   input  logic          clr_we,
   input  logic          mask_we,
   input  logic [NB-1:0] wd,
   output logic [NB-1:0] status,
   output logic [NB-1:0] mask,
   output logic          irq
);
   logic [NB-1:0] clr;

   assign clr = clr_we ? wd : '0;
   assign irq = |(status & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
      end else begin
         status <= (status & ~clr) | ev;
         if (mask_we) mask <= wd;
      end
   end
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm import rtc_pkg::*; #(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 6,
   parameter int TICKS_PER_MS = 32,
   parameter int MS_PER_SEC   = 1000,
   parameter int SYNC_TICKS   = 8,
   parameter int BUSY_LEN     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int MS_W  = $clog2(MS_PER_SEC);
   localparam int IDX_W = ADDR_W - 2;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (TICKS_PER_MS < 2 || MS_PER_SEC < 2) begin : g_bad_div
      $error("TICKS_PER_MS and MS_PER_SEC must be at least 2");
   end
   if (SYNC_TICKS < 2 || (SYNC_TICKS & (SYNC_TICKS - 1)) != 0) begin : g_bad_sync
      $error("SYNC_TICKS must be a power of two of at least 2");
   end
   if (BUSY_LEN < 1 || DATA_W < MS_W || DATA_W < NUM_EV) begin : g_bad_width
      $error("BUSY_LEN or DATA_W out of range");
   end

   logic [IDX_W-1:0] widx;
   logic             acc_ok, rd_en, wr_ok, busy, snap, ld_sec;
   logic [DATA_W-1:0] al_sec [NUM_SEC_AL];
   logic [MS_W-1:0]  al_ms;
   logic [DATA_W-1:0] sec_nxt, view_sec, shadow_q;
   logic [MS_W-1:0]  ms_nxt, view_ms;
   logic [NUM_EV-1:0] ev_vec, stat_q, mask_q;
   logic [DATA_W-1:0] rd_val;

   function automatic logic is_reg(input logic [IDX_W-1:0] w, input int r);
      return w == IDX_W'(r);
   endfunction

   assign widx   = bus_addr[ADDR_W-1:2];
   assign acc_ok = bus_sel && (bus_addr[1:0] == 2'b00);
   assign rd_en  = acc_ok && !bus_wr;
   assign wr_ok  = acc_ok && bus_wr && !busy;
   assign snap   = rd_en && is_reg(widx, RG_MS);
   assign ld_sec = wr_ok && is_reg(widx, RG_SEC);

   for (genvar k = 0; k < NUM_SEC_AL; k++) begin : g_sal_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                        al_sec[k] <= '0;
         else if (wr_ok && is_reg(widx, int'(RG_SAL_A) + k)) al_sec[k] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              al_ms <= '0;
      else if (wr_ok && is_reg(widx, RG_MSAL)) al_ms <= bus_wdata[MS_W-1:0];
   end

   rtc_timebase #(
      .SEC_W(DATA_W), .MS_W(MS_W),
      .TICKS_PER_MS(TICKS_PER_MS), .MS_PER_SEC(MS_PER_SEC)
   ) i_timebase (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick),
      .load(ld_sec), .load_val(bus_wdata),
      .al_sec(al_sec), .al_ms(al_ms),
      .sec_nxt(sec_nxt), .ms_nxt(ms_nxt), .ev(ev_vec)
   );

   rtc_sync_view #(
      .SEC_W(DATA_W), .MS_W(MS_W),
      .SYNC_TICKS(SYNC_TICKS), .BUSY_LEN(BUSY_LEN)
   ) i_view (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick),
      .sec_nxt(sec_nxt), .ms_nxt(ms_nxt), .snap(snap),
      .busy(busy), .view_sec(view_sec), .view_ms(view_ms), .shadow(shadow_q)
   );

   rtc_irq_ctrl #(.NB(NUM_EV)) i_irq (
      .clk(clk), .rst_n(rst_n), .ev(ev_vec),
      .clr_we(wr_ok && is_reg(widx, RG_STAT)),
      .mask_we(wr_ok && is_reg(widx, RG_MASK)),
      .wd(bus_wdata[NUM_EV-1:0]),
      .status(stat_q), .mask(mask_q), .irq(irq)
   );

   always_comb begin
      rd_val = '0;
      case (widx)
         IDX_W'(RG_BUSY):   rd_val = DATA_W'(busy);
         IDX_W'(RG_SEC):    rd_val = view_sec;
         IDX_W'(RG_SHADOW): rd_val = shadow_q;
         IDX_W'(RG_MS):     rd_val = DATA_W'(view_ms);
         IDX_W'(RG_SAL_A):  rd_val = al_sec[0];
         IDX_W'(RG_SAL_B):  rd_val = al_sec[1];
         IDX_W'(RG_MSAL):   rd_val = DATA_W'(al_ms);
         IDX_W'(RG_MASK):   rd_val = DATA_W'(mask_q);
         IDX_W'(RG_STAT):   rd_val = DATA_W'(stat_q);
         default:           rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk import rtc_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6,
   parameter int NB     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NB-1:0]     bus_wd,
   input logic              irq,
   input logic              busy,
   input logic [NB-1:0]     ev,
   input logic [NB-1:0]     status,
   input logic [NB-1:0]     mask,
   input logic [DATA_W-1:0] al0,
   input logic [DATA_W-1:0] shadow
);
   localparam int IDX_W = ADDR_W - 2;
   logic acc, ms_rd, stat_wr;

   assign acc     = bus_sel && (bus_addr[1:0] == 2'b00);
   assign ms_rd   = acc && !bus_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(RG_MS));
   assign stat_wr = acc && bus_wr && !busy && (bus_addr[ADDR_W-1:2] == IDX_W'(RG_STAT));

   // R2: a refresh window opens only right after a slow tick
   assert_busy_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tick));

   // R3: writes during busy leave the mask untouched
   assert_busy_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_sel && bus_wr) |=> $stable(mask));

   // R5: shadow only moves on a millisecond-view read
   assert_shadow_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_rd |=> $stable(shadow));

   // R7: a zero alarm value never produces its event
   assert_zero_alarm_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev[EV_SAL_A] |-> (al0 != '0));

   // R9: ones written to status clear those bits when no event competes
   assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && ev == '0) |=> ((status & $past(bus_wd)) == '0));

   // R10: an enabled event raises the interrupt on the next cycle
   assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (((ev & mask) != '0) && !(bus_sel && bus_wr)) |=> irq);

   // R11: a new event beats a simultaneous clear
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((status & $past(ev)) == $past(ev)));
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NB(rtc_pkg::NUM_EV)
) i_chk (
   .clk(clk), .rst_n(rst_n), .tick(slow_tick),
   .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wd(bus_wdata[rtc_pkg::NUM_EV-1:0]),
   .irq(irq), .busy(busy), .ev(ev_vec), .status(stat_q), .mask(mask_q),
   .al0(al_sec[0]), .shadow(shadow_q)
);

// File: tb/test_rtc_sec_alarm.sv
module test_rtc_sec_alarm;
   import rtc_pkg::*;

   localparam int TPM = 2;
   localparam int MPS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [31:0] v;

   always #5 clk = ~clk;

   rtc_sec_alarm #(
      .DATA_W(32), .ADDR_W(6), .TICKS_PER_MS(TPM), .MS_PER_SEC(MPS),
      .SYNC_TICKS(8), .BUSY_LEN(4)
   ) i_rtc_sec_alarm (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   typedef struct packed {
      logic [3:0]  idx;
      logic [31:0] wd;
      logic [31:0] ex;
   } vec_t;

   // R12: write / read-back table
   localparam vec_t VEC [6] = '{
      '{4'(RG_SAL_B), 32'hDEADBEEF, 32'hDEADBEEF},
      '{4'(RG_MSAL),  32'hFFFFFFFF, 32'h0000000F},
      '{4'(RG_MASK),  32'hFFFFFFFF, 32'h0000001F},
      '{4'(RG_MASK),  32'h00000000, 32'h00000000},
      '{4'(RG_SAL_A), 32'h12345678, 32'h12345678},
      '{4'(RG_SAL_A), 32'h00000000, 32'h00000000}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [3:0] r, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {r, 2'b00}; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [3:0] r, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {r, 2'b00};
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic expect_rd(input string tag, input logic [3:0] r, input logic [31:0] exp);
      logic [31:0] d;
      do_rd(r, d);
      check(tag, d, exp);
   endtask

   task automatic ticks(input int n, input int idle);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) slow_tick = 1'b1;
         @(negedge clk) slow_tick = 1'b0;
         repeat (idle) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      expect_rd("R1 busy", RG_BUSY, 32'h0);
      expect_rd("R1 status", RG_STAT, 32'h0);
      expect_rd("R1 seconds", RG_SEC, 32'h0);
      expect_rd("R1 mask", RG_MASK, 32'h0);

      // R12: table walk
      foreach (VEC[i]) begin
         do_wr(VEC[i].idx, VEC[i].wd);
         expect_rd($sformatf("R12 vector %0d", i), VEC[i].idx, VEC[i].ex);
      end

      // R4 / R2 / R3: refresh cadence, busy window and blocked write
      ticks(7, 3);
      expect_rd("R4 ms view before refresh", RG_MS, 32'd0);
      ticks(1, 0);
      expect_rd("R2 busy after eighth tick", RG_BUSY, 32'd1);
      do_wr(RG_MASK, 32'h1);
      repeat (4) @(negedge clk);
      expect_rd("R3 write during busy ignored", RG_MASK, 32'h0);
      expect_rd("R2 busy cleared", RG_BUSY, 32'd0);
      expect_rd("R4 ms view after refresh", RG_MS, 32'd4);
      expect_rd("R5 shadow from ms read", RG_SHADOW, 32'd0);

      // R6: seconds load visible after next refresh
      do_wr(RG_SEC, 32'd100);
      expect_rd("R6 seconds view unchanged", RG_SEC, 32'd0);
      ticks(8, 3);
      expect_rd("R6 seconds view after refresh", RG_SEC, 32'd100);
      expect_rd("R5 shadow holds", RG_SHADOW, 32'd0);
      expect_rd("R6 ms cleared by load", RG_MS, 32'd4);
      expect_rd("R5 shadow latched", RG_SHADOW, 32'd100);

      // R4 / R5 / R8: cross a second boundary
      ticks(16, 3);
      expect_rd("R5 shadow stale until ms read", RG_SHADOW, 32'd100);
      expect_rd("R4 ms after wrap", RG_MS, 32'd2);
      expect_rd("R4 seconds advanced", RG_SHADOW, 32'd101);
      expect_rd("R8 periodic bits masked", RG_STAT, 32'h18);
      check("R10 masked no irq", {31'b0, irq}, 32'h0);

      // R9: write-one-to-clear
      do_wr(RG_STAT, 32'h08);
      expect_rd("R9 partial clear", RG_STAT, 32'h10);
      do_wr(RG_STAT, 32'h10);
      expect_rd("R9 full clear", RG_STAT, 32'h0);

      // R7 / R10: seconds alarm A drives irq
      do_wr(RG_SAL_A, 32'd102);
      do_wr(RG_MASK, 32'h01);
      ticks(15, 3);
      check("R10 irq before alarm", {31'b0, irq}, 32'h0);
      ticks(1, 3);
      check("R10 irq on alarm", {31'b0, irq}, 32'h1);
      expect_rd("R7 alarm A status", RG_STAT, 32'h19);
      do_wr(RG_STAT, 32'h1F);
      check("R10 irq drops after clear", {31'b0, irq}, 32'h0);

      // R11: clear collides with a millisecond event
      ticks(1, 3);
      @(negedge clk);
      slow_tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1;
      bus_addr = {4'(RG_STAT), 2'b00}; bus_wdata = 32'h10;
      @(negedge clk);
      slow_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      repeat (4) @(negedge clk);
      expect_rd("R11 set wins over clear", RG_STAT, 32'h10);

      // R7 / R8: zero alarm across a wrap, alarm B and ms alarm
      do_wr(RG_STAT, 32'h1F);
      do_wr(RG_SAL_A, 32'd0);
      do_wr(RG_SAL_B, 32'd1);
      do_wr(RG_MSAL, 32'd5);
      do_wr(RG_SEC, 32'hFFFFFFFF);
      ticks(20, 3);
      expect_rd("R7 zero alarm silent on wrap", RG_STAT, 32'h1C);
      check("R7 no irq from zero alarm", {31'b0, irq}, 32'h0);
      ticks(20, 3);
      expect_rd("R8 alarm B and ms alarm", RG_STAT, 32'h1E);
      do_wr(RG_MASK, 32'h02);
      check("R10 irq with alarm B enabled", {31'b0, irq}, 32'h1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule